// File: doc/BRIEF.md
# Privileged Far-Call Stack Switcher

This block carries out the stack side of a far call made through a call gate and of the far return that undoes it. On a call it receives the caller's code and stack registers, the gate's target selector, offset, parameter count and target privilege. When the target is more privileged, it picks a fresh stack pointer pair from a per-privilege table. It then pushes the caller's stack registers onto the fresh stack, copies the gate's parameter words across from the old stack, and pushes the return address. On a return it pops the return address, compares the selector's RPL with the current level, discards the parameters and, when privilege drops, pops and restores the caller's stack.

All stack traffic goes through one word-wide memory port that holds each request until it is acknowledged. The port carries the segment selector and the byte address. Descriptor lookups are replaced by direct inputs: the table gives, for each level, a selector, a pointer, a type-valid flag and a DPL. When an operation ends, `done` pulses for one cycle. The register values the caller should adopt are then held on the outputs. If the operation is refused, `fault` rises and those outputs return the values the operation started with.

Top module: `gate_call_seq`

## Requirements
- R1: After reset `done`, `fault`, `busy` and `mem_req` are all 0.
- R2: A call whose target level is numerically below the current level takes the selector and pointer from table entry number `tgt_dpl`. Each push first lowers ESP by 4 and then writes. The caller's SS, zero-extended, goes to new ESP-4 and the caller's ESP goes to new ESP-8.
- R3: On such a call exactly `gate_pcnt` words (0 to 31) are copied, keeping their layout. With B = table ESP - 8 - 4*pcnt and old pointer E, the word at old E+4k lands at new B+4k.
- R4: After the parameters, the caller's CS (zero-extended) is pushed to B-4 and then EIP to B-8, and the final ESP is B-8. A successful call performs exactly 4+pcnt writes.
- R5: A successful call ends with CS = {gate_idx, tgt_dpl}, EIP = gate_off and CPL = tgt_dpl.
- R6: If the selected table entry is flagged invalid, or its DPL differs from `tgt_dpl`, the call faults. `done` and `fault` rise the cycle after the start, the outputs equal the start values, and no memory access occurs.
- R7: A call with `tgt_dpl` above `cur_cpl` faults in the same way as R6.
- R8: A call with `tgt_dpl` equal to `cur_cpl` keeps the current stack and copies nothing. It pushes CS to ESP-4 and EIP to ESP-8, performing exactly 2 writes.
- R9: A return pops EIP from ESP and CS from ESP+4. When the popped RPL exceeds `cur_cpl`, it skips `ret_imm` bytes and then pops ESP and SS. The final ESP is the popped ESP plus `ret_imm`, and CPL becomes the RPL.
- R10: A return whose popped RPL equals `cur_cpl` leaves SS and CPL as they were and ends with ESP = start ESP + 8 + `ret_imm`.
- R11: A return whose popped RPL is below `cur_cpl` faults, and the outputs equal the start values.
- R12: While a memory request waits for its acknowledge, its address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_call | input | 1 | Begin a gated far call (taken when idle) |
| start_ret | input | 1 | Begin a far return (taken when idle) |
| cur_cpl | input | 2 | Current privilege level |
| cur_cs | input | 16 | Caller code selector |
| cur_eip | input | 32 | Caller return offset |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| gate_idx | input | 14 | Target code selector without its RPL bits |
| gate_off | input | 32 | Target entry offset |
| gate_pcnt | input | 5 | Parameter words to copy |
| tgt_dpl | input | 2 | Privilege level of the target code |
| ret_imm | input | 16 | Bytes of parameters to discard on return |
| stk_ss_tbl | input | 64 | Per-level stack selectors, level n in bits 16n+15..16n |
| stk_esp_tbl | input | 128 | Per-level stack pointers, level n in bits 32n+31..32n |
| stk_ok_tbl | input | 4 | Per-level stack descriptor type valid |
| stk_dpl_tbl | input | 8 | Per-level stack descriptor DPL, level n in bits 2n+1..2n |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_seg | output | 16 | Segment selector of the access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last operation was refused |
| out_cpl | output | 2 | Resulting privilege level |
| out_cs | output | 16 | Resulting code selector |
| out_eip | output | 32 | Resulting instruction pointer |
| out_ss | output | 16 | Resulting stack selector |
| out_esp | output | 32 | Resulting stack pointer |

## Verification
Several properties are checked on every cycle. The assertions confirm that a waiting request holds still and that no request is open when the completion pulse is high. They also confirm that a successful result always carries a code selector whose RPL equals the reported level. Both refusal paths for a call, bad table entry and less-privileged target, must report a fault one cycle after the start. Frame layout, parameter order, the double use of the return's immediate and the value restoration after a fault are shown only by the bench. It sweeps every current/target level pair against parameter counts up to 31 and follows each call with its matching return.

// File: rtl/gcs_pkg.sv
// Shared definitions for the gated far-call stack switcher.
// Assumes four privilege levels and a 5-bit gate parameter count.
package gcs_pkg;
    localparam int unsigned PLW = 2;   // privilege level width
    localparam int unsigned PCW = 5;   // parameter count width

    typedef enum logic [3:0] {
        S_IDLE, S_PSS, S_PESP, S_RPRM, S_WPRM, S_PCS, S_PEIP,
        S_REIP, S_RCS, S_RESP, S_RSS, S_FIN
    } gcs_state_e;
endpackage

// File: rtl/gcs_stack_pick.sv
// Selects the stack pointer pair for a target privilege level from a
// flattened per-level table and judges the entry's descriptor.
// Assumes the table entry index equals the privilege level.
module gcs_stack_pick #(
    parameter int unsigned PLW = 2,
    localparam int unsigned NPL = 1 << PLW
) (
    input  logic [PLW-1:0]     sel_lvl,
    input  logic [NPL*16-1:0]  tbl_ss,
    input  logic [NPL*32-1:0]  tbl_esp,
    input  logic [NPL-1:0]     tbl_ok,
    input  logic [NPL*PLW-1:0] tbl_dpl,
    output logic [15:0]        pick_ss,
    output logic [31:0]        pick_esp,
    output logic               pick_ok
);
    logic [15:0]    ss_a  [NPL];
    logic [31:0]    esp_a [NPL];
    logic [PLW-1:0] dpl_a [NPL];

    // Unpack one table entry per level.
    for (genvar g = 0; g < NPL; g++) begin : g_ent
        assign ss_a[g]  = tbl_ss[g*16 +: 16];
        assign esp_a[g] = tbl_esp[g*32 +: 32];
        assign dpl_a[g] = tbl_dpl[g*PLW +: PLW];
    end

    // Entry usable only if its type is valid and its DPL matches the level.
    always_comb begin
        pick_ss  = ss_a[sel_lvl];
        pick_esp = esp_a[sel_lvl];
        pick_ok  = tbl_ok[sel_lvl] && (dpl_a[sel_lvl] == sel_lvl);
    end
endmodule

// File: rtl/gcs_engine.sv
// Sequencer for gated far calls and far returns. Performs stack pushes,
// parameter copying and pops through a held request/acknowledge port.
// Assumes the selected stack entry was already judged by gcs_stack_pick
// and that start pulses arrive only while idle (others are ignored).
module gcs_engine
    import gcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_call,
    input  logic           start_ret,
    input  logic [PLW-1:0] cur_cpl,
    input  logic [15:0]    cur_cs,
    input  logic [31:0]    cur_eip,
    input  logic [15:0]    cur_ss,
    input  logic [31:0]    cur_esp,
    input  logic [13:0]    gate_idx,
    input  logic [31:0]    gate_off,
    input  logic [PCW-1:0] gate_pcnt,
    input  logic [PLW-1:0] tgt_dpl,
    input  logic [15:0]    ret_imm,
    input  logic [15:0]    new_ss,
    input  logic [31:0]    new_esp,
    input  logic           new_ok,
    output logic           mem_req,
    output logic           mem_we,
    output logic [15:0]    mem_seg,
    output logic [31:0]    mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata,
    output logic           busy,
    output logic           done,
    output logic           fault,
    output logic [PLW-1:0] out_cpl,
    output logic [15:0]    out_cs,
    output logic [31:0]    out_eip,
    output logic [15:0]    out_ss,
    output logic [31:0]    out_esp
);
    gcs_state_e     st;
    logic [15:0]    w_ss, old_ss, ret_cs, pop_cs;
    logic [31:0]    w_esp, old_esp, ret_eip, pop_eip, pop_esp, pword, tgt_eip, imm32;
    logic [PCW-1:0] cnt;
    logic [PLW-1:0] lvl_q, tgt_q;
    logic [13:0]    tgt_idx;
    logic [31:0]    prm_off;

    assign imm32   = {16'h0000, ret_imm_q};
    assign prm_off = {{(32-PCW){1'b0}}, cnt - 1'b1} << 2;
    assign busy    = (st != S_IDLE);
    assign done    = (st == S_FIN);

    logic [15:0] ret_imm_q;

    // Drive the memory port from the current step.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_seg   = w_ss;
        mem_addr  = w_esp - 32'd4;
        mem_wdata = 32'h0;
        unique case (st)
            S_PSS:  mem_wdata = {16'h0000, old_ss};
            S_PESP: mem_wdata = old_esp;
            S_WPRM: mem_wdata = pword;
            S_PCS:  mem_wdata = {16'h0000, ret_cs};
            S_PEIP: mem_wdata = ret_eip;
            S_RPRM: begin
                mem_we   = 1'b0;
                mem_seg  = old_ss;
                mem_addr = old_esp + prm_off;
            end
            S_REIP, S_RCS, S_RESP, S_RSS: begin
                mem_we   = 1'b0;
                mem_addr = w_esp;
            end
            default: begin
                mem_req = 1'b0;
                mem_we  = 1'b0;
            end
        endcase
    end

    // Step the call/return sequence and register the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
            fault <= 1'b0;
            {w_ss, old_ss, ret_cs, pop_cs, out_cs, out_ss} <= '0;
            {w_esp, old_esp, ret_eip, pop_eip, pop_esp, pword, tgt_eip} <= '0;
            {out_eip, out_esp} <= '0;
            cnt <= '0; lvl_q <= '0; tgt_q <= '0; tgt_idx <= '0;
            ret_imm_q <= '0; out_cpl <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    ret_cs <= cur_cs; ret_eip <= cur_eip;
                    old_ss <= cur_ss; old_esp <= cur_esp;
                    lvl_q <= cur_cpl; tgt_q <= tgt_dpl;
                    tgt_idx <= gate_idx; tgt_eip <= gate_off;
                    ret_imm_q <= ret_imm; cnt <= gate_pcnt;
                    if (start_call) begin
                        if (tgt_dpl > cur_cpl || (tgt_dpl < cur_cpl && !new_ok)) begin
                            fault <= 1'b1;
                            out_cs <= cur_cs; out_eip <= cur_eip;
                            out_ss <= cur_ss; out_esp <= cur_esp; out_cpl <= cur_cpl;
                            st <= S_FIN;
                        end else if (tgt_dpl < cur_cpl) begin
                            w_ss <= new_ss; w_esp <= new_esp;
                            st <= S_PSS;
                        end else begin
                            w_ss <= cur_ss; w_esp <= cur_esp;
                            st <= S_PCS;
                        end
                    end else if (start_ret) begin
                        w_ss <= cur_ss; w_esp <= cur_esp;
                        st <= S_REIP;
                    end
                end
                S_PSS: if (mem_ack) begin
                    w_esp <= w_esp - 32'd4; st <= S_PESP;
                end
                S_PESP: if (mem_ack) begin
                    w_esp <= w_esp - 32'd4;
                    st <= (cnt == '0) ? S_PCS : S_RPRM;
                end
                S_RPRM: if (mem_ack) begin
                    pword <= mem_rdata; st <= S_WPRM;
                end
                S_WPRM: if (mem_ack) begin
                    w_esp <= w_esp - 32'd4;
                    cnt <= cnt - 1'b1;
                    st <= (cnt == 1) ? S_PCS : S_RPRM;
                end
                S_PCS: if (mem_ack) begin
                    w_esp <= w_esp - 32'd4; st <= S_PEIP;
                end
                S_PEIP: if (mem_ack) begin
                    fault <= 1'b0;
                    out_cs <= {tgt_idx, tgt_q}; out_eip <= tgt_eip;
                    out_ss <= w_ss; out_esp <= w_esp - 32'd4; out_cpl <= tgt_q;
                    st <= S_FIN;
                end
                S_REIP: if (mem_ack) begin
                    pop_eip <= mem_rdata; w_esp <= w_esp + 32'd4; st <= S_RCS;
                end
                S_RCS: if (mem_ack) begin
                    pop_cs <= mem_rdata[15:0];
                    if (mem_rdata[PLW-1:0] < lvl_q) begin
                        fault <= 1'b1;
                        out_cs <= ret_cs; out_eip <= ret_eip;
                        out_ss <= old_ss; out_esp <= old_esp; out_cpl <= lvl_q;
                        st <= S_FIN;
                    end else if (mem_rdata[PLW-1:0] > lvl_q) begin
                        w_esp <= w_esp + 32'd4 + imm32;
                        st <= S_RESP;
                    end else begin
                        fault <= 1'b0;
                        out_cs <= mem_rdata[15:0]; out_eip <= pop_eip;
                        out_ss <= w_ss; out_esp <= w_esp + 32'd4 + imm32; out_cpl <= lvl_q;
                        st <= S_FIN;
                    end
                end
                S_RESP: if (mem_ack) begin
                    pop_esp <= mem_rdata; w_esp <= w_esp + 32'd4; st <= S_RSS;
                end
                S_RSS: if (mem_ack) begin
                    fault <= 1'b0;
                    out_cs <= pop_cs; out_eip <= pop_eip;
                    out_ss <= mem_rdata[15:0]; out_esp <= pop_esp + imm32;
                    out_cpl <= pop_cs[PLW-1:0];
                    st <= S_FIN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_seg) && $stable(mem_wdata));

    // R12
    no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R5
    rpl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> out_cs[PLW-1:0] == out_cpl);

    // R7
    lower_target_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) && start_call && (tgt_dpl > cur_cpl) |=> done && fault);
endmodule

// File: rtl/gate_call_seq.sv
// Top of the gated far-call stack switcher: joins the per-level stack
// table selector to the call/return sequencer.
// Assumes four privilege levels; table entries are indexed by level.
module gate_call_seq
    import gcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_call,
    input  logic           start_ret,
    input  logic [1:0]     cur_cpl,
    input  logic [15:0]    cur_cs,
    input  logic [31:0]    cur_eip,
    input  logic [15:0]    cur_ss,
    input  logic [31:0]    cur_esp,
    input  logic [13:0]    gate_idx,
    input  logic [31:0]    gate_off,
    input  logic [4:0]     gate_pcnt,
    input  logic [1:0]     tgt_dpl,
    input  logic [15:0]    ret_imm,
    input  logic [63:0]    stk_ss_tbl,
    input  logic [127:0]   stk_esp_tbl,
    input  logic [3:0]     stk_ok_tbl,
    input  logic [7:0]     stk_dpl_tbl,
    output logic           mem_req,
    output logic           mem_we,
    output logic [15:0]    mem_seg,
    output logic [31:0]    mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata,
    output logic           busy,
    output logic           done,
    output logic           fault,
    output logic [1:0]     out_cpl,
    output logic [15:0]    out_cs,
    output logic [31:0]    out_eip,
    output logic [15:0]    out_ss,
    output logic [31:0]    out_esp
);
    logic [15:0] n_ss;
    logic [31:0] n_esp;
    logic        n_ok;

    gcs_stack_pick #(.PLW(PLW)) u_pick (
        .sel_lvl(tgt_dpl), .tbl_ss(stk_ss_tbl), .tbl_esp(stk_esp_tbl),
        .tbl_ok(stk_ok_tbl), .tbl_dpl(stk_dpl_tbl),
        .pick_ss(n_ss), .pick_esp(n_esp), .pick_ok(n_ok)
    );

    gcs_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start_call(start_call), .start_ret(start_ret),
        .cur_cpl(cur_cpl), .cur_cs(cur_cs), .cur_eip(cur_eip), .cur_ss(cur_ss),
        .cur_esp(cur_esp), .gate_idx(gate_idx), .gate_off(gate_off),
        .gate_pcnt(gate_pcnt), .tgt_dpl(tgt_dpl), .ret_imm(ret_imm),
        .new_ss(n_ss), .new_esp(n_esp), .new_ok(n_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .out_cpl(out_cpl),
        .out_cs(out_cs), .out_eip(out_eip), .out_ss(out_ss), .out_esp(out_esp)
    );

    // R6
    bad_stack_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start_call && (tgt_dpl < cur_cpl) && !n_ok |=> done && fault);
endmodule

// File: tb/gate_call_seq_tb.sv
// Self-checking bench: sweeps level pairs and parameter counts, pairs each
// call with its return, and exercises every refusal path.
module gate_call_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_call = 0, start_ret = 0;
    logic [1:0] cur_cpl = 0, tgt_dpl = 0;
    logic [15:0] cur_cs = 0, cur_ss = 0, ret_imm = 0;
    logic [31:0] cur_eip = 0, cur_esp = 0, gate_off = 0;
    logic [13:0] gate_idx = 0;
    logic [4:0] gate_pcnt = 0;
    logic [63:0] stk_ss_tbl;
    logic [127:0] stk_esp_tbl;
    logic [3:0] stk_ok_tbl;
    logic [7:0] stk_dpl_tbl;
    logic mem_req, mem_we, mem_ack = 0;
    logic [15:0] mem_seg;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic busy, done, fault;
    logic [1:0] out_cpl;
    logic [15:0] out_cs, out_ss;
    logic [31:0] out_eip, out_esp;

    int errors = 0, checks = 0, writes = 0, accesses = 0;
    logic [31:0] mem [logic [47:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_call_seq u_dut (.*);

    // Memory model: one access per request, acknowledge a cycle later.
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            accesses <= accesses + 1;
            if (mem_we) begin
                mem[{mem_seg, mem_addr}] = mem_wdata;
                writes <= writes + 1;
            end else
                mem_rdata <= mem.exists({mem_seg, mem_addr}) ? mem[{mem_seg, mem_addr}] : 32'hDEAD_BEEF;
            mem_ack <= 1'b1;
        end else
            mem_ack <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [15:0] s, input logic [31:0] a);
        return mem.exists({s, a}) ? mem[{s, a}] : 32'hDEAD_BEEF;
    endfunction

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (!done) chk(1'b0, {req, " timeout"}, 0, 1);
    endtask

    task automatic pulse(input bit is_call);
        @(negedge clk);
        if (is_call) start_call = 1; else start_ret = 1;
        @(negedge clk);
        start_call = 0; start_ret = 0;
    endtask

    function automatic logic [31:0] tesp(input int l);
        return 32'h0000_8000 + 32'(l) * 32'h1000;
    endfunction

    function automatic logic [15:0] tss(input int l);
        return 16'h0100 + 16'(l) * 16'h8;
    endfunction

    initial begin
        for (int l = 0; l < 4; l++) begin
            stk_ss_tbl[l*16 +: 16] = tss(l);
            stk_esp_tbl[l*32 +: 32] = tesp(l);
            stk_dpl_tbl[l*2 +: 2] = 2'(l);
        end
        stk_ok_tbl = 4'hF;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !fault && !busy && !mem_req, "R1", {done, fault, busy, mem_req}, 0);
        rst_n = 1;
        @(negedge clk);

        // Sweep: every more-privileged target from every level, several counts.
        for (int c = 1; c < 4; c++) begin
            for (int t = 0; t < c; t++) begin
                for (int pi = 0; pi < 6; pi++) begin
                    automatic int n = (pi == 5) ? 31 : ((pi == 4) ? 7 : pi);
                    automatic logic [15:0] oss = 16'h0040 + 16'(c);
                    automatic logic [31:0] oesp = 32'h0002_0000 - 32'(pi) * 32'h100;
                    automatic logic [15:0] ocs = {13'(c * 3 + pi), 1'b0, 2'(c)};
                    automatic logic [31:0] oeip = 32'h1000_0000 + 32'(c * 64 + t * 8 + pi);
                    automatic logic [31:0] B = tesp(t) - 32'd8 - 32'(4 * n);
                    automatic int bad = 0;
                    automatic int w0;
                    mem.delete();
                    for (int k = 0; k < n; k++) mem[{oss, oesp + 32'(4 * k)}] = 32'hA500_0000 + 32'(k * 17 + c);
                    cur_cpl = 2'(c); tgt_dpl = 2'(t); cur_cs = ocs; cur_eip = oeip;
                    cur_ss = oss; cur_esp = oesp; gate_idx = 14'(16'h0200 + 16'(pi));
                    gate_off = 32'h0040_0000 + 32'(pi); gate_pcnt = 5'(n);
                    w0 = writes;
                    pulse(1);
                    wait_done("R2");
                    chk(!fault, "R2 no fault", {31'h0, fault}, 0);
                    chk(out_ss == tss(t) && rd(tss(t), tesp(t) - 4) == {16'h0, oss}
                        && rd(tss(t), tesp(t) - 8) == oesp, "R2 stack switch", rd(tss(t), tesp(t) - 8), oesp);
                    for (int k = 0; k < n; k++)
                        if (rd(tss(t), B + 32'(4 * k)) != rd(oss, oesp + 32'(4 * k))) bad++;
                    chk(bad == 0, "R3 parameter copy", 32'(bad), 0);
                    chk(rd(tss(t), B - 4) == {16'h0, ocs} && rd(tss(t), B - 8) == oeip,
                        "R4 return frame", rd(tss(t), B - 8), oeip);
                    chk(out_esp == B - 8, "R4 final esp", out_esp, B - 8);
                    chk(writes - w0 == 4 + n, "R4 write count", 32'(writes - w0), 32'(4 + n));
                    chk(out_cs == {gate_idx, 2'(t)} && out_eip == gate_off && out_cpl == 2'(t),
                        "R5 target", {out_cs, 14'h0, out_cpl}, {gate_idx, 2'(t), 14'h0, 2'(t)});
                    // Matching return: R9
                    cur_cpl = out_cpl; cur_cs = out_cs; cur_eip = out_eip;
                    cur_ss = out_ss; cur_esp = out_esp; ret_imm = 16'(4 * n);
                    @(negedge clk);
                    pulse(0);
                    wait_done("R9");
                    chk(!fault && out_cs == ocs && out_eip == oeip && out_ss == oss
                        && out_cpl == 2'(c), "R9 restore", {out_ss, out_cs}, {oss, ocs});
                    chk(out_esp == oesp + 32'(4 * n), "R9 esp", out_esp, oesp + 32'(4 * n));
                    @(negedge clk);
                end
            end
        end

        // R6: invalid type on the chosen entry
        begin
            automatic int a0;
            mem.delete();
            stk_ok_tbl = 4'b1110;
            cur_cpl = 3; tgt_dpl = 0; cur_cs = 16'h0073; cur_eip = 32'h1234;
            cur_ss = 16'h007B; cur_esp = 32'h3000; gate_pcnt = 3;
            a0 = accesses;
            pulse(1);
            chk(done && fault, "R6 type fault timing", {30'h0, done, fault}, 3);
            chk(out_cs == 16'h0073 && out_eip == 32'h1234 && out_ss == 16'h007B
                && out_esp == 32'h3000 && out_cpl == 3, "R6 outputs kept", out_esp, 32'h3000);
            chk(accesses == a0, "R6 no memory", 32'(accesses - a0), 0);
            stk_ok_tbl = 4'hF;
            @(negedge clk);
            // R6: DPL mismatch
            stk_dpl_tbl[2 +: 2] = 2'd2;
            tgt_dpl = 1;
            a0 = accesses;
            pulse(1);
            chk(done && fault && accesses == a0, "R6 dpl fault", {30'h0, done, fault}, 3);
            stk_dpl_tbl[2 +: 2] = 2'd1;
            @(negedge clk);
            // R7: less privileged target
            cur_cpl = 1; tgt_dpl = 2;
            a0 = accesses;
            pulse(1);
            chk(done && fault && accesses == a0 && out_cpl == 1, "R7 outward call fault",
                {30'h0, done, fault}, 3);
            @(negedge clk);
        end

        // R8: same-level call, then R10 same-level return
        begin
            automatic int w0 = writes;
            mem.delete();
            cur_cpl = 2; tgt_dpl = 2; cur_cs = 16'h005A; cur_eip = 32'h0000_7777;
            cur_ss = 16'h0062; cur_esp = 32'h5000; gate_idx = 14'h0123;
            gate_off = 32'h0000_9999; gate_pcnt = 5;
            pulse(1);
            wait_done("R8");
            chk(!fault && out_ss == 16'h0062 && out_esp == 32'h4FF8 && out_cpl == 2,
                "R8 same stack", out_esp, 32'h4FF8);
            chk(rd(16'h0062, 32'h4FFC) == 32'h005A && rd(16'h0062, 32'h4FF8) == 32'h7777
                && writes - w0 == 2, "R8 frame", 32'(writes - w0), 2);
            cur_cs = out_cs; cur_eip = out_eip; cur_esp = out_esp; ret_imm = 16'd12;
            @(negedge clk);
            pulse(0);
            wait_done("R10");
            chk(!fault && out_cs == 16'h005A && out_eip == 32'h7777 && out_ss == 16'h0062
                && out_cpl == 2 && out_esp == 32'h4FF8 + 32'd20, "R10 same-level return",
                out_esp, 32'h500C);
            @(negedge clk);
        end

        // R11: return to a more privileged selector is refused
        mem.delete();
        mem[{16'h0070, 32'h6000}] = 32'h0000_4444;
        mem[{16'h0070, 32'h6004}] = 32'h0000_0010;
        cur_cpl = 2; cur_cs = 16'h0022; cur_eip = 32'h8888; cur_ss = 16'h0070;
        cur_esp = 32'h6000; ret_imm = 16'd8;
        pulse(0);
        wait_done("R11");
        chk(fault && out_cs == 16'h0022 && out_eip == 32'h8888 && out_ss == 16'h0070
            && out_esp == 32'h6000 && out_cpl == 2, "R11 inward return fault", out_esp, 32'h6000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule